// File: doc/BRIEF.md
# Floating-Point Sum Renormalization Unit

This block is the final stage of a double-precision add/subtract pipeline. The stage before it has already aligned the two significands and added them. This block takes that raw two's-complement sum, together with the tentative result exponent (the exponent of the larger operand) and the tentative sign. It produces a packed 64-bit IEEE 754 double and seven status flags, registered one clock after the input.

The sum is first turned into a sign and a magnitude. A carry into the upper integer bit moves the value right by one place. Cancellation moves it left under the control of a combinational leading-one detector. That left shift is clamped so that the exponent stops at its lowest normal value, which is how gradual underflow to denormals comes about. Rounding follows, using round-to-nearest-even on guard, round and sticky. The last step packs the result, with overflow to infinity, exact zero, and NaN or infinity pass-through.

The sum input `sum_i` is 58 bits wide. Bit 57 is the two's-complement sign. Bits 56:55 are the two integer bits, with bit 55 the hidden-bit position. Bits 54:3 are the 52 fraction bits. Bits 2, 1 and 0 are guard, round and sticky. The value is sum_i / 2^55 × 2^(exp_i − 1023). For a finite input, `exp_i` lies in 1..2046, and operands that were denormal count as having exponent 1.

Top module: `fp_sum_renorm`

## Requirements
- R1: A negative `sum_i` is negated before normalization, and the result sign is `sign_i` XOR bit 57. A nonnegative sum keeps `sign_i`.
- R2: When magnitude bit 56 is set, the significand shifts right by one and the exponent rises by one. The bit shifted out is ORed into sticky.
- R3: Otherwise the significand shifts left by the leading-zero count above bit 55, found combinationally, and the exponent drops by that count. After such a shift, bit 55 holds a one.
- R4: If the full left shift would take the exponent below 1, the shift stops at exponent 1 and the exponent field is written as 0. A nonzero fraction with exponent field 0 raises the denormal flag (flags bit 4).
- R5: Rounding is round-to-nearest-even on bits 2:0, applied after the shift. A carry out of the significand raises the exponent by one. A denormal that rounds up to 1.0 × 2^-1022 gets exponent field 1.
- R6: The inexact flag (bit 5) is set when any of guard, round or sticky is nonzero after the shift, and also on overflow.
- R7: If the rounded exponent reaches 2047, the result is infinity with the computed sign (field 2047, fraction 0). The overflow flag (bit 1) and the inexact flag are set.
- R8: A zero magnitude gives +0. A nonzero value that rounds to nothing keeps its sign. Both set the zero flag (bit 0).
- R9: `nan_i` or `invalid_i` gives the quiet NaN 0x7FF8000000000000 with the NaN flag (bit 2). `invalid_i` also sets the invalid flag (bit 6).
- R10: `inf_i` (without NaN or invalid) gives infinity signed by `sign_i`, and leaves the overflow flag clear.
- R11: `overshift_i` is copied to flags bit 3 for every result that is not NaN or infinity.
- R12: `out_valid` is high exactly one cycle after `in_valid`. Result and flags change only on a valid input. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| sum_i | input | 58 | Raw two's-complement significand sum with guard bits |
| exp_i | input | 11 | Tentative biased result exponent |
| sign_i | input | 1 | Tentative result sign |
| nan_i | input | 1 | An operand was NaN |
| inf_i | input | 1 | Result is infinity from an infinite operand |
| invalid_i | input | 1 | Invalid operation (infinities of opposite sign) |
| overshift_i | input | 1 | Alignment shifted the smaller operand fully out |
| out_valid | output | 1 | Result and flags are valid |
| result_o | output | 64 | Packed IEEE 754 double result |
| flags_o | output | 7 | {invalid, inexact, denormal, overshift, nan, overflow, zero} |

## Verification
The bench aims at the edges of the shift paths.

- **Carry at exponent 2046.** A design that forgot to saturate here would wrap to a tiny number instead of infinity.
- **Cancellation at small exponents.** A missing clamp would drive the exponent negative or emit a normal number below the normal range.
- **Rounding ties with even and odd LSB.** A wrong tie rule shows up as a fraction off by one.
- **All-ones denormal rounding up into the normal range.** A fixed zero exponent field would give a wrong value here.
- **Exact cancellation of negative sums.** This exposes a −0 result or a sign that was not flipped.
- **NaN, invalid and infinity inputs mixed with random finite sums.** These show any special case leaking into the finite path.

// File: rtl/rnorm_pkg.sv
package rnorm_pkg;
    parameter int EXP_W  = 11;
    parameter int FRAC_W = 52;
    parameter int GRS_W  = 3;

    localparam int SIG_W   = FRAC_W + 1;
    localparam int NORM_W  = SIG_W + GRS_W;
    localparam int MAG_W   = NORM_W + 1;
    localparam int SUM_W   = MAG_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int EXT_W   = EXP_W + 2;
    localparam int LZ_W    = $clog2(NORM_W);
    localparam int FLAG_W  = 7;
    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    typedef enum logic [2:0] {
        SIG_KEEP, SIG_RSH1, SIG_LSH, SIG_CLAMP, SIG_ZERO
    } sig_act_e;

    typedef enum logic [1:0] {
        EXA_SAME, EXA_INC, EXA_SUB, EXA_ZERO
    } exp_act_e;

    typedef struct packed {
        logic [NORM_W-1:0] sig;
        logic [EXT_W-1:0]  exp;
        sig_act_e          act;
    } norm_t;

    typedef struct packed {
        logic invalid;
        logic inexact;
        logic denormal;
        logic overshift;
        logic nan;
        logic overflow;
        logic zero;
    } flags_t;

    function automatic logic [WORD_W-1:0] quiet_nan();
        return {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/rnorm_lod.sv
module rnorm_lod
    import rnorm_pkg::*;
#(
    parameter int W = NORM_W,
    localparam int ZW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [ZW-1:0] lzc_o,
    output logic          none_o
);
    // Priority scan from LSB upward; the highest set bit wins the last write.
    always_comb begin
        lzc_o  = '0;
        none_o = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                lzc_o  = ZW'(W - 1 - i);
                none_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rnorm_align.sv
module rnorm_align
    import rnorm_pkg::*;
(
    input  logic [MAG_W-1:0] mag_i,
    input  logic [EXP_W-1:0] exp_i,
    output norm_t            norm_o
);
    logic [LZ_W-1:0]  lzc;
    logic             none;
    logic [EXT_W-1:0] room, lz_ext, shamt;
    sig_act_e         sact;
    exp_act_e         eact;

    rnorm_lod #(.W(NORM_W)) u_lod (
        .vec_i  (mag_i[NORM_W-1:0]),
        .lzc_o  (lzc),
        .none_o (none)
    );

    assign room   = EXT_W'(exp_i) - EXT_W'(1);
    assign lz_ext = EXT_W'(lzc);

    always_comb begin
        shamt = '0;
        if (mag_i[MAG_W-1]) begin
            sact = SIG_RSH1;
            eact = EXA_INC;
        end else if (none) begin
            sact = SIG_ZERO;
            eact = EXA_ZERO;
        end else if (lz_ext <= room) begin
            shamt = lz_ext;
            sact  = (lzc == '0) ? SIG_KEEP : SIG_LSH;
            eact  = (lzc == '0) ? EXA_SAME : EXA_SUB;
        end else begin
            shamt = room;
            sact  = SIG_CLAMP;
            eact  = EXA_SUB;
        end
    end

    always_comb begin
        norm_o.act = sact;
        unique case (sact)
            SIG_KEEP:  norm_o.sig = mag_i[NORM_W-1:0];
            SIG_RSH1:  norm_o.sig = {mag_i[MAG_W-1:2], |mag_i[1:0]};
            SIG_LSH,
            SIG_CLAMP: norm_o.sig = mag_i[NORM_W-1:0] << shamt;
            default:   norm_o.sig = '0;
        endcase
        unique case (eact)
            EXA_SAME: norm_o.exp = EXT_W'(exp_i);
            EXA_INC:  norm_o.exp = EXT_W'(exp_i) + EXT_W'(1);
            EXA_SUB:  norm_o.exp = EXT_W'(exp_i) - shamt;
            default:  norm_o.exp = '0;
        endcase
    end

    always_comb begin
        if (norm_o.act == SIG_KEEP || norm_o.act == SIG_RSH1 || norm_o.act == SIG_LSH) begin
            // R3
            lead_one_chk: assert (norm_o.sig[NORM_W-1]);
        end
        if (norm_o.act == SIG_CLAMP) begin
            // R4
            clamp_short_chk: assert (!norm_o.sig[NORM_W-1]);
        end
    end
endmodule

// File: rtl/rnorm_round.sv
module rnorm_round
    import rnorm_pkg::*;
(
    input  norm_t              norm_i,
    input  logic               sign_i,
    output logic [WORD_W-1:0]  word_o,
    output logic               zero_o,
    output logic               ovf_o,
    output logic               den_o,
    output logic               inexact_o
);
    logic             lsb, guard, rest, up;
    logic [SIG_W:0]   rsum;
    logic [SIG_W-1:0] sig_f;
    logic [EXT_W-1:0] exp_f;
    logic [EXP_W-1:0] fexp;
    logic [FRAC_W-1:0] ffrac;

    assign lsb   = norm_i.sig[GRS_W];
    assign guard = norm_i.sig[GRS_W-1];
    assign rest  = |norm_i.sig[GRS_W-2:0];
    assign up    = guard & (rest | lsb);
    assign rsum  = {1'b0, norm_i.sig[NORM_W-1:GRS_W]} + (SIG_W+1)'(up);

    always_comb begin
        if (rsum[SIG_W]) begin
            sig_f = rsum[SIG_W:1];
            exp_f = norm_i.exp + EXT_W'(1);
        end else begin
            sig_f = rsum[SIG_W-1:0];
            exp_f = norm_i.exp;
        end
        ovf_o = exp_f >= EXT_W'(EXP_ONES);
        if (ovf_o) begin
            fexp  = EXP_ONES;
            ffrac = '0;
        end else begin
            fexp  = sig_f[SIG_W-1] ? exp_f[EXP_W-1:0] : '0;
            ffrac = sig_f[FRAC_W-1:0];
        end
        word_o    = {sign_i, fexp, ffrac};
        inexact_o = (|norm_i.sig[GRS_W-1:0]) | ovf_o;
        zero_o    = !ovf_o && fexp == '0 && ffrac == '0;
        den_o     = !ovf_o && fexp == '0 && ffrac != '0;
    end
endmodule

// File: rtl/fp_sum_renorm.sv
module fp_sum_renorm
    import rnorm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SUM_W-1:0]  sum_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              sign_i,
    input  logic              nan_i,
    input  logic              inf_i,
    input  logic              invalid_i,
    input  logic              overshift_i,
    output logic              out_valid,
    output logic [WORD_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic              neg, sgn;
    logic [SUM_W-1:0]  negsum;
    logic [MAG_W-1:0]  mag;
    norm_t             nrm;
    logic [WORD_W-1:0] fin_word, res_d, res_q;
    logic              f_zero, f_ovf, f_den, f_inex;
    flags_t            flg_d, flg_q;

    assign neg    = sum_i[SUM_W-1];
    assign negsum = -sum_i;
    assign mag    = neg ? negsum[MAG_W-1:0] : sum_i[MAG_W-1:0];

    rnorm_align u_align (
        .mag_i  (mag),
        .exp_i  (exp_i),
        .norm_o (nrm)
    );

    assign sgn = (nrm.act == SIG_ZERO) ? 1'b0 : (sign_i ^ neg);

    rnorm_round u_round (
        .norm_i    (nrm),
        .sign_i    (sgn),
        .word_o    (fin_word),
        .zero_o    (f_zero),
        .ovf_o     (f_ovf),
        .den_o     (f_den),
        .inexact_o (f_inex)
    );

    always_comb begin
        flg_d = '0;
        if (nan_i || invalid_i) begin
            res_d         = quiet_nan();
            flg_d.nan     = 1'b1;
            flg_d.invalid = invalid_i;
        end else if (inf_i) begin
            res_d = {sign_i, EXP_ONES, {FRAC_W{1'b0}}};
        end else begin
            res_d           = fin_word;
            flg_d.zero      = f_zero;
            flg_d.overflow  = f_ovf;
            flg_d.denormal  = f_den;
            flg_d.inexact   = f_inex;
            flg_d.overshift = overshift_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
            flg_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
                flg_q <= flg_d;
            end
        end
    end

    assign result_o = res_q;
    assign flags_o  = flg_q;

    // R8
    zero_word_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flg_q.zero) |-> (result_o[WORD_W-2:0] == '0));

    // R4
    denorm_field_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flg_q.denormal) |->
        (result_o[WORD_W-2 -: EXP_W] == '0 && result_o[FRAC_W-1:0] != '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flg_q.overflow) |->
        (result_o[WORD_W-2 -: EXP_W] == EXP_ONES && result_o[FRAC_W-1:0] == '0 && flg_q.inexact));

    // R9
    nan_word_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flg_q.nan) |-> (result_o == quiet_nan()));

    // R12
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result_o) && $stable(flags_o)));
endmodule

// File: tb/fp_sum_renorm_test.sv
module fp_sum_renorm_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [57:0] sum_i;
    logic [10:0] exp_i;
    logic        sign_i, nan_i, inf_i, invalid_i, overshift_i;
    logic        out_valid;
    logic [63:0] result_o;
    logic [6:0]  flags_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fp_sum_renorm uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sum_i(sum_i), .exp_i(exp_i),
        .sign_i(sign_i), .nan_i(nan_i), .inf_i(inf_i), .invalid_i(invalid_i),
        .overshift_i(overshift_i), .out_valid(out_valid), .result_o(result_o),
        .flags_o(flags_o)
    );

    // Flags: [0] zero [1] ovf [2] nan [3] overshift [4] denormal [5] inexact [6] invalid
    function automatic logic [70:0] model(logic [57:0] s, logic [10:0] ei, logic sg,
                                          logic nn, logic inf, logic inv, logic osh);
        logic [6:0]  f;
        logic [63:0] w;
        logic [57:0] t;
        logic [56:0] m;
        logic [53:0] big;
        logic [2:0]  grs;
        logic        neg, so;
        int          e;
        f = '0;
        if (nn || inv) begin
            f[2] = 1'b1; f[6] = inv;
            return {f, 64'h7FF8000000000000};
        end
        if (inf) return {f, sg, 11'h7FF, 52'd0};
        f[3] = osh;
        neg = s[57];
        t = -s;
        m = neg ? t[56:0] : s[56:0];
        so = sg ^ neg;
        if (m == '0) begin
            f[0] = 1'b1;
            return {f, 64'd0};
        end
        e = int'(ei);
        if (m[56]) begin
            m = (m >> 1) | (m & 57'd1);
            e++;
        end else begin
            while (!m[55] && e > 1) begin
                m = m << 1;
                e--;
            end
        end
        grs = m[2:0];
        big = {1'b0, m[55:3]};
        if (grs[2] && (grs[1] || grs[0] || m[3])) big = big + 54'd1;
        if (big[53]) begin
            big = big >> 1;
            e++;
        end
        if (e >= 2047) begin
            f[1] = 1'b1; f[5] = 1'b1;
            return {f, so, 11'h7FF, 52'd0};
        end
        w = {so, (big[52] ? 11'(e) : 11'd0), big[51:0]};
        f[5] = (grs != 3'b000);
        f[0] = (w[62:0] == '0);
        f[4] = (w[62:52] == '0) && (w[51:0] != '0);
        return {f, w};
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(string req, logic [57:0] s, logic [10:0] e, logic sg,
                       logic nn, logic inf, logic inv, logic osh);
        logic [70:0] x;
        x = model(s, e, sg, nn, inf, inv, osh);
        sum_i = s; exp_i = e; sign_i = sg; nan_i = nn; inf_i = inf;
        invalid_i = inv; overshift_i = osh; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " result"}, result_o, x[63:0]);
        check({req, " flags"}, 64'(flags_o), 64'(x[70:64]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b0; sum_i = '0; exp_i = '0; sign_i = 1'b0;
        nan_i = 1'b0; inf_i = 1'b0; invalid_i = 1'b0; overshift_i = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset valid", 64'(out_valid), 64'd0);
        check("R12 reset result", result_o, 64'd0);
        check("R12 reset flags", 64'(flags_o), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R8 exact cancellation gives +0
        run("R8 cancel", 58'd0, 11'd700, 1'b1, 0, 0, 0, 0);
        check("R8 plus zero", result_o, 64'd0);
        // R9 NaN and invalid
        run("R9 nan", 58'd12345, 11'd10, 1'b1, 1, 0, 0, 0);
        check("R9 nan word", result_o, 64'h7FF8000000000000);
        run("R9 invalid", 58'd1, 11'd10, 1'b0, 0, 1, 1, 0);
        check("R9 invalid flags", 64'(flags_o), 64'h44);
        // R10 infinity passthrough
        run("R10 inf", 58'd1 << 56, 11'd2046, 1'b1, 0, 1, 0, 0);
        check("R10 inf word", result_o, 64'hFFF0000000000000);
        // R7 overflow from carry at top exponent
        run("R7 ovf", 58'd1 << 56, 11'd2046, 1'b0, 0, 0, 0, 0);
        check("R7 ovf word", result_o, 64'h7FF0000000000000);
        check("R7 ovf flags", 64'(flags_o), 64'h22);
        // R2 carry with sticky fold
        run("R2 carry", (58'd3 << 55) | 58'd1, 11'd100, 1'b0, 0, 0, 0, 0);
        // R5 ties
        run("R5 tie even", (58'd1 << 55) | (58'd1 << 2), 11'd500, 1'b0, 0, 0, 0, 0);
        check("R5 tie even word", result_o, {1'b0, 11'd500, 52'd0});
        run("R5 tie odd", (58'd1 << 55) | (58'd3 << 2), 11'd500, 1'b0, 0, 0, 0, 0);
        check("R5 tie odd word", result_o, {1'b0, 11'd500, 52'd2});
        // R5 denormal rounds up into normal range
        run("R5 den to norm", ((58'd1 << 53) - 58'd1) << 2, 11'd1, 1'b0, 0, 0, 0, 0);
        check("R5 den to norm word", result_o, {1'b0, 11'd1, 52'd0});
        // R4 clamp
        run("R4 clamp", 58'd1 << 50, 11'd3, 1'b0, 0, 0, 0, 0);
        check("R4 den flag", 64'(flags_o[4]), 64'd1);
        run("R4 den exp1", 58'd1 << 10, 11'd1, 1'b0, 0, 0, 0, 0);
        // R3 deep cancellation, R1 negative sum
        run("R3 lsh", 58'd1 << 20, 11'd900, 1'b0, 0, 0, 0, 0);
        run("R1 neg", -(58'd5 << 40), 11'd900, 1'b0, 0, 0, 0, 0);
        check("R1 sign", 64'(result_o[63]), 64'd1);
        // R8 underflow to signed zero
        run("R8 underflow", -58'd3, 11'd1, 1'b0, 0, 0, 0, 0);
        check("R8 neg zero", result_o, 64'h8000000000000000);
        // R11 overshift forwarded
        run("R11 osh", 58'd1 << 55, 11'd77, 1'b0, 0, 0, 0, 1);
        check("R11 osh flag", 64'(flags_o[3]), 64'd1);
        // R12 hold while idle
        held = result_o;
        @(negedge clk);
        check("R12 idle valid", 64'(out_valid), 64'd0);
        check("R12 idle hold", result_o, held);

        for (int n = 0; n < 3000; n++) begin
            logic [57:0] b;
            logic [10:0] e;
            int sel;
            b = 58'({$urandom, $urandom});
            b = b >> $urandom_range(1, 57);
            if ($urandom_range(0, 1) == 1) b = -b;
            sel = $urandom_range(0, 2);
            if (sel == 0) e = 11'($urandom_range(1, 60));
            else if (sel == 1) e = 11'($urandom_range(1990, 2046));
            else e = 11'($urandom_range(1, 2046));
            sel = $urandom_range(0, 39);
            run("R1 R2 R3 R4 R5 R6 R7 random", b, e, 1'($urandom),
                sel == 0, sel == 1, sel == 2, 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule